// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column access request into the run of column addresses that an SDRAM burst walks through. A one-cycle `start` pulse captures the start column, a burst length code and an order select. From the next clock on, the block presents one column address per cycle together with a valid flag. It raises a final-beat flag on the closing address of a fixed-length burst. A `stop` request cuts any burst short, whatever its length.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned group of that size. In sequential order the group wraps upward from the start offset. In interleaved order each beat index is XORed into the low bits. The full-page length steps through the whole 9-bit column space, wraps from the top column back to zero, and continues until it is stopped. A new `start` may arrive on any cycle, including during a burst, so column commands can follow each other on every clock.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released with no start, `col_valid` and `last_beat` are 0 and `col_addr` is 0.
- R2: A `start` sampled at a rising edge makes `col_valid` 1 from the next cycle with `col_addr` equal to the captured `start_col`, and one new address follows on every later cycle of the burst.
- R3: `bl_code` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and any code with bit 2 set gives full page. An unstopped fixed burst shows exactly that many valid cycles, then `col_valid` returns to 0.
- R4: With `interleave` = 0 and a fixed length BL, beat i has the upper column bits of the start column and low log2(BL) bits equal to (start low bits + i) mod BL.
- R5: With `interleave` = 1 and a fixed length BL, beat i has the upper column bits of the start column and low log2(BL) bits equal to the start low bits XOR i.
- R6: In full page, beat i is (start_col + i) mod 512, wrapping from 511 to 0. The burst continues until stopped, and `interleave` has no effect on it.
- R7: `last_beat` is 1 exactly in the cycle showing the final beat of a fixed-length burst (the only beat when the length is 1). It is never 1 in full page and never 1 while `col_valid` is 0.
- R8: A `stop` sampled at an edge while a burst is valid and `start` is 0 ends the burst: `col_valid` is 0 in the next cycle. A `stop` while idle has no effect.
- R9: A `start` during a burst abandons it and begins the new burst from the next cycle. When `start` and `stop` are sampled together, `start` wins.
- R10: Whenever `col_valid` is 0, `col_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the parameters on this cycle |
| start_col | input | 9 | First column of the burst |
| bl_code | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 0 = sequential order, 1 = interleaved order |
| stop | input | 1 | End the current burst after this cycle |
| col_valid | output | 1 | A burst address is presented this cycle |
| col_addr | output | 9 | Column address of the current beat |
| last_beat | output | 1 | Current beat is the final one of a fixed burst |

## Verification
A beat counter that slips, or a length mask that is latched wrongly, shows at the ports in the very cycle it happens. The address leaves its aligned group, changes upper bits it should hold, or skips a value in the wrap order. `last_beat` also lands on the wrong beat, or the valid window comes out longer or shorter than the length code promises. A lost `stop` or `start` shows one cycle after its edge, as `col_valid` staying high or failing to rise. Full-page runs started near column 511 expose a wrap that is carried into bits outside the column width, and full-page runs with interleave set expose an order select that leaks into that mode.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Length code: low bits give log2 of a fixed length, top bit selects full page.
  localparam int unsigned BL_CODE_W   = 3;
  localparam int unsigned FIXED_LOG_W = BL_CODE_W - 1;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [BL_CODE_W-1:0] bl_code,
  output logic [COL_W-1:0]     len_mask,
  output logic                 full_page
);

  logic [FIXED_LOG_W-1:0] log_len;

  assign full_page = bl_code[BL_CODE_W-1];
  assign log_len   = bl_code[FIXED_LOG_W-1:0];

  // Bit k of the mask is set when it lies inside the wrap group.
  for (genvar k = 0; k < COL_W; k++) begin : g_mask
    assign len_mask[k] = full_page | (k < int'(log_len));
  end

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_page_in,
  input  order_e           order_in,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_page_q,
  output order_e           order_q,
  output logic             final_beat
);

  logic finish_evt;

  // Final beat of a fixed burst: the counter has reached the group size minus one.
  assign final_beat = active & ~full_page_q & (beat == mask_q);
  assign finish_evt = active & (stop | final_beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      beat        <= '0;
      base_q      <= '0;
      mask_q      <= '0;
      full_page_q <= 1'b0;
      order_q     <= ORD_SEQ;
    end else if (start) begin
      active      <= 1'b1;
      beat        <= '0;
      base_q      <= start_col;
      mask_q      <= mask_in;
      full_page_q <= full_page_in;
      order_q     <= order_in;
    end else if (finish_evt) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (active) begin
      beat <= beat + COL_W'(1);
    end
  end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             active,
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             full_page,
  input  order_e           order,
  output logic [COL_W-1:0] addr
);

  function automatic logic [COL_W-1:0] wrap_addr(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] i, input logic [COL_W-1:0] m);
    logic [COL_W-1:0] sum;
    sum = b + i;
    return (b & ~m) | (sum & m);
  endfunction

  function automatic logic [COL_W-1:0] xor_addr(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] i, input logic [COL_W-1:0] m);
    return (b & ~m) | ((b ^ i) & m);
  endfunction

  logic [COL_W-1:0] seq_a;
  logic [COL_W-1:0] ilv_a;
  logic             use_ilv;

  assign seq_a   = wrap_addr(base, beat, mask);
  assign ilv_a   = xor_addr(base, beat, mask);
  // Full page always walks upward.
  assign use_ilv = (order == ORD_ILV) & ~full_page;

  always_comb begin
    if (!active)      addr = '0;
    else if (use_ilv) addr = ilv_a;
    else              addr = seq_a;
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [COL_W-1:0]     start_col,
  input  logic [BL_CODE_W-1:0] bl_code,
  input  logic                 interleave,
  input  logic                 stop,
  output logic                 col_valid,
  output logic [COL_W-1:0]     col_addr,
  output logic                 last_beat
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             burst_on;
  logic [COL_W-1:0] beat_idx;
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] grp_mask;
  logic             page_mode;
  order_e           order_sel;
  order_e           order_in;
  logic             at_final;

  assign order_in = interleave ? ORD_ILV : ORD_SEQ;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .bl_code   (bl_code),
    .len_mask  (dec_mask),
    .full_page (dec_full)
  );

  colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .stop         (stop),
    .start_col    (start_col),
    .mask_in      (dec_mask),
    .full_page_in (dec_full),
    .order_in     (order_in),
    .active       (burst_on),
    .beat         (beat_idx),
    .base_q       (base_col),
    .mask_q       (grp_mask),
    .full_page_q  (page_mode),
    .order_q      (order_sel),
    .final_beat   (at_final)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .active    (burst_on),
    .base      (base_col),
    .beat      (beat_idx),
    .mask      (grp_mask),
    .full_page (page_mode),
    .order     (order_sel),
    .addr      (col_addr)
  );

  assign col_valid = burst_on;
  assign last_beat = at_final;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             last_beat,
  input logic             page_mode,
  input logic [COL_W-1:0] grp_mask
);

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr == $past(start_col)));

  a_r3_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !col_valid);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !col_valid);

  a_r7_last_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  a_r7_no_last_full_page: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && page_mode) |-> !last_beat);

  a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && page_mode && !start && !stop) |=>
      (col_valid && col_addr == COL_W'($past(col_addr) + COL_W'(1))));

  a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !start && !stop && !last_beat) |=>
      ((col_addr & ~grp_mask) == ($past(col_addr) & ~grp_mask)));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (col_addr == '0));

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stop      (stop),
  .start_col (start_col),
  .col_valid (col_valid),
  .col_addr  (col_addr),
  .last_beat (last_beat),
  .page_mode (page_mode),
  .grp_mask  (grp_mask)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [2:0] bl_code = '0;
  logic       interleave = 1'b0;
  logic       stop = 1'b0;
  logic       col_valid;
  logic [8:0] col_addr;
  logic       last_beat;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .bl_code    (bl_code),
    .interleave (interleave),
    .stop       (stop),
    .col_valid  (col_valid),
    .col_addr   (col_addr),
    .last_beat  (last_beat)
  );

  function automatic int burst_len(int code);
    if (code >= 4) return 512;
    return 1 << code;
  endfunction

  function automatic int exp_addr(int base, int code, bit ilv, int i);
    int bl, off, grp;
    if (code >= 4) return (base + i) % 512;
    bl  = 1 << code;
    off = base % bl;
    grp = base - off;
    if (ilv) return grp + (off ^ (i % bl));
    return grp + ((off + i) % bl);
  endfunction

  task automatic chk(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual valid/last/addr=%b/%b/%0d expected %b/%b/%0d",
               tag, act[10], act[9], act[8:0], exp[10], exp[9], exp[8:0]);
    end
  endtask

  task automatic chk_idle(string tag);
    chk(tag, {col_valid, last_beat, col_addr}, 11'd0);
  endtask

  // Drive a start at a falling edge; returns at the next falling edge showing beat 0.
  task automatic kick(int col, int code, bit ilv, bit st);
    start = 1'b1; start_col = 9'(col); bl_code = 3'(code); interleave = ilv; stop = st;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic watch(string tag, int base, int code, bit ilv,
                       int from_i, int upto, int stop_at, bit tail);
    for (int i = from_i; i <= upto; i++) begin
      logic lst;
      lst = (code < 4) && (i == burst_len(code) - 1);
      chk(tag, {col_valid, last_beat, col_addr}, {1'b1, lst, 9'(exp_addr(base, code, ilv, i))});
      stop = (i == stop_at);
      @(negedge clk);
    end
    stop = 1'b0;
    if (tail) chk_idle(tag);
  endtask

  task automatic burst(string tag, int base, int code, bit ilv, int stop_at);
    int upto;
    upto = burst_len(code) - 1;
    if (stop_at >= 0 && stop_at < upto) upto = stop_at;
    kick(base, code, ilv, 1'b0);
    watch(tag, base, code, ilv, 0, upto, stop_at, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    // R3/R7: single beat, then each fixed length, both orders
    burst("R3 R7 length one", 9'd77, 0, 1'b0, -1);
    burst("R4 seq len2", 9'd13, 1, 1'b0, -1);
    burst("R4 seq len4", 9'd6, 2, 1'b0, -1);
    burst("R4 seq len8", 9'd301, 3, 1'b0, -1);
    burst("R5 ilv len4", 9'd6, 2, 1'b1, -1);
    burst("R5 ilv len8", 9'd301, 3, 1'b1, -1);

    // R6: full page wrap across 511, and interleave ignored
    burst("R6 page wrap", 9'd509, 7, 1'b0, 6);
    burst("R6 page ilv ignored", 9'd510, 4, 1'b1, 4);

    // R8: stop mid-burst and stop on the first beat
    burst("R8 stop mid len8", 9'd40, 3, 1'b0, 2);
    burst("R8 stop beat0 len4", 9'd41, 2, 1'b1, 0);

    // R8: stop while idle has no effect on a following burst
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk_idle("R8 stop idle");
    burst("R8 burst after idle stop", 9'd200, 2, 1'b0, -1);

    // R9: restart mid-burst
    kick(100, 3, 1'b0, 1'b0);
    watch("R9 first burst", 100, 3, 1'b0, 0, 2, -1, 1'b0);
    kick(255, 2, 1'b1, 1'b0);
    watch("R9 restarted burst", 255, 2, 1'b1, 0, 3, -1, 1'b1);

    // R9: start and stop together, start wins
    kick(58, 1, 1'b0, 1'b1);
    watch("R9 start beats stop", 58, 1, 1'b0, 0, 1, -1, 1'b1);

    // R10: idle address after a stopped page burst
    burst("R10 idle after page", 9'd0, 6, 1'b0, 3);

    // Random bursts over all codes, orders and stop points
    for (int n = 0; n < 60; n++) begin
      int c, b, s;
      bit o;
      c = int'($urandom % 8);
      b = int'($urandom % 512);
      o = 1'($urandom % 2);
      if (c >= 4) begin
        if (($urandom % 3) == 0) b = 500 + int'($urandom % 12);
        s = int'($urandom % 24);
      end else begin
        s = int'($urandom % (burst_len(c) + 3));
        if (s >= burst_len(c)) s = -1;
      end
      burst(o ? "R5 R6 R8 random" : "R4 R6 R8 random", b, c, o, s);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule